// File: doc/BRIEF.md
# Cipher Control Register with Key-Length Sanitization

This block is the control word of a block-cipher engine. It keeps four settings: the direction of operation (encrypt or decrypt), a one-hot key-length selector, a manual-start flag and a force-overwrite flag. Software writes and reads the word through a simple address/data port. The cipher core receives each setting as a value, together with a one-cycle strobe that marks every software write of the word.

Software may write any 3-bit pattern into the key-length field. Some of those patterns are not legal. If 192-bit keys are compiled out, the 192-bit code is also not accepted. After every write, the block replaces the stored field with a legal code in the next cycle. A read therefore always shows the key length the core really uses. The core never sees a pattern that is not legal, not even in the single cycle where the raw written value still sits in the register.

Top module: `cipher_ctrl_reg`

## Requirements
- R1: After reset the control word reads 0x00000002: direction 0, key length 3'b001, manual start 0, force overwrite 0. All write strobes to the core are low.
- R2: The word layout is: bit 0 direction, bits 3:1 key length, bit 4 manual start, bit 5 force overwrite. Bits above 5 read as zero. A read at any address other than the control address returns zero.
- R3: A write to the control address with `sw_wr_en_i` high updates direction, manual start and force overwrite at the next rising clock edge.
- R4: Each field's strobe to the core is high for exactly the one cycle that follows the edge which captured a software write. It is low in every other cycle.
- R5: The key-length codes 3'b001 (128-bit) and 3'b100 (256-bit) are kept unchanged.
- R6: The code 3'b010 (192-bit) is kept when `EN192` is 1. It is replaced by 3'b001 when `EN192` is 0.
- R7: The codes 3'b000, 3'b011, 3'b101, 3'b110 and 3'b111 are replaced by 3'b001.
- R8: In the cycle that carries the key-length strobe, the stored key-length field is overwritten with its legal code. A read one cycle after the write shows the legal code.
- R9: `core_keylen_o` always carries a legal code. This includes the cycle in which the raw written pattern is stored.
- R10: If a software write captures in the same edge as the key-length write-back, the write-back wins for the key-length field. The other fields take the new software values.
- R11: A write with an address other than the control address changes no field and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_wr_en_i | input | 1 | Software write enable |
| sw_addr_i | input | ADDR_W | Software address for reads and writes |
| sw_wdata_i | input | DATA_W | Software write data |
| sw_rdata_o | output | DATA_W | Software read data (combinational) |
| core_mode_o | output | 1 | Direction: 0 encrypt, 1 decrypt |
| core_mode_qe_o | output | 1 | Direction write strobe |
| core_keylen_o | output | 3 | Legal one-hot key length |
| core_keylen_qe_o | output | 1 | Key-length write strobe |
| core_start_o | output | 1 | Manual-start flag |
| core_start_qe_o | output | 1 | Manual-start write strobe |
| core_fover_o | output | 1 | Force-overwrite flag |
| core_fover_qe_o | output | 1 | Force-overwrite write strobe |

## Verification
The bench writes all eight 3-bit key-length patterns to two instances: one built with 192-bit support and one built without it. This shows which patterns are kept, which are remapped, and where the two builds differ. The direction, start and overwrite bits are derived from each pattern, so their positions are exercised with varying values. Each write is observed twice: in the strobe cycle, to see the core value while the raw pattern is still stored, and one cycle later, to see the read-back after the write-back. Further cases cover the following:
- an all-ones word, which checks the upper-bit masking;
- a write to a foreign address;
- back-to-back writes, which separate write-back priority from plain last-write-wins behaviour.

// File: rtl/cipher_ctrl_pkg.sv
package cipher_ctrl_pkg;

    localparam int KL_W      = 3;
    localparam int MODE_BIT  = 0;
    localparam int KL_LSB    = 1;
    localparam int START_BIT = KL_LSB + KL_W;
    localparam int FOVER_BIT = START_BIT + 1;
    localparam int CTRL_USED = FOVER_BIT + 1;

    typedef enum logic [KL_W-1:0] {
        KL_128 = 3'b001,
        KL_192 = 3'b010,
        KL_256 = 3'b100
    } keylen_e;

    typedef struct packed {
        logic            fover;
        logic            start;
        logic [KL_W-1:0] keylen;
        logic            mode;
    } ctrl_word_t;

endpackage

// File: rtl/cipher_keylen_sanitize.sv
module cipher_keylen_sanitize
    import cipher_ctrl_pkg::*;
#(
    parameter bit EN192 = 1'b1
) (
    input  logic [KL_W-1:0] raw_i,
    output logic [KL_W-1:0] legal_o
);

    always_comb begin
        unique case (raw_i)
            KL_128:  legal_o = KL_128;
            KL_256:  legal_o = KL_256;
            KL_192:  legal_o = EN192 ? KL_192 : KL_128;
            default: legal_o = KL_128;
        endcase
    end

endmodule

// File: rtl/cipher_ctrl_field.sv
module cipher_ctrl_field #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter bit           HW_WR   = 1'b0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         sw_we_i,
    input  logic [W-1:0] sw_wd_i,
    input  logic         hw_de_i,
    input  logic [W-1:0] hw_d_i,
    output logic [W-1:0] q_o,
    output logic         qe_o
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         qe;
    } fld_state_t;

    fld_state_t st_d, st_q;
    logic       hw_sel;

    generate
        if (HW_WR) begin : g_hw
            assign hw_sel = hw_de_i;
        end else begin : g_sw_only
            logic unused_hw;
            assign unused_hw = hw_de_i ^ (^hw_d_i);
            assign hw_sel    = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        st_d.qe = sw_we_i;
        if (hw_sel) begin
            st_d.val = hw_d_i;
        end else if (sw_we_i) begin
            st_d.val = sw_wd_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.val <= RST_VAL;
            st_q.qe  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o  = st_q.val;
    assign qe_o = st_q.qe;

endmodule

// File: rtl/cipher_ctrl_reg.sv
module cipher_ctrl_reg
    import cipher_ctrl_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h8,
    parameter bit              EN192     = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sw_wr_en_i,
    input  logic [ADDR_W-1:0] sw_addr_i,
    input  logic [DATA_W-1:0] sw_wdata_i,
    output logic [DATA_W-1:0] sw_rdata_o,
    output logic              core_mode_o,
    output logic              core_mode_qe_o,
    output logic [2:0]        core_keylen_o,
    output logic              core_keylen_qe_o,
    output logic              core_start_o,
    output logic              core_start_qe_o,
    output logic              core_fover_o,
    output logic              core_fover_qe_o
);

    localparam int PAD_W = DATA_W - CTRL_USED;

    logic            wr_hit;
    logic            addr_hit;
    ctrl_word_t      wr_word;
    ctrl_word_t      cur_word;
    logic [KL_W-1:0] keylen_q;
    logic [KL_W-1:0] keylen_legal;
    logic            unused_wdata;

    assign addr_hit = (sw_addr_i == CTRL_ADDR);
    assign wr_hit   = sw_wr_en_i && addr_hit;
    assign wr_word  = ctrl_word_t'(sw_wdata_i[CTRL_USED-1:0]);
    assign unused_wdata = ^sw_wdata_i[DATA_W-1:CTRL_USED];

    cipher_ctrl_field #(.W(1), .RST_VAL(1'b0), .HW_WR(1'b0)) u_mode (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sw_we_i (wr_hit),
        .sw_wd_i (wr_word.mode),
        .hw_de_i (1'b0),
        .hw_d_i  (1'b0),
        .q_o     (core_mode_o),
        .qe_o    (core_mode_qe_o)
    );

    cipher_ctrl_field #(.W(KL_W), .RST_VAL(KL_128), .HW_WR(1'b1)) u_keylen (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sw_we_i (wr_hit),
        .sw_wd_i (wr_word.keylen),
        .hw_de_i (core_keylen_qe_o),
        .hw_d_i  (keylen_legal),
        .q_o     (keylen_q),
        .qe_o    (core_keylen_qe_o)
    );

    cipher_ctrl_field #(.W(1), .RST_VAL(1'b0), .HW_WR(1'b0)) u_start (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sw_we_i (wr_hit),
        .sw_wd_i (wr_word.start),
        .hw_de_i (1'b0),
        .hw_d_i  (1'b0),
        .q_o     (core_start_o),
        .qe_o    (core_start_qe_o)
    );

    cipher_ctrl_field #(.W(1), .RST_VAL(1'b0), .HW_WR(1'b0)) u_fover (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sw_we_i (wr_hit),
        .sw_wd_i (wr_word.fover),
        .hw_de_i (1'b0),
        .hw_d_i  (1'b0),
        .q_o     (core_fover_o),
        .qe_o    (core_fover_qe_o)
    );

    cipher_keylen_sanitize #(.EN192(EN192)) u_sanitize (
        .raw_i   (keylen_q),
        .legal_o (keylen_legal)
    );

    assign core_keylen_o = keylen_legal;

    always_comb begin
        cur_word.mode   = core_mode_o;
        cur_word.keylen = keylen_q;
        cur_word.start  = core_start_o;
        cur_word.fover  = core_fover_o;
        sw_rdata_o      = addr_hit ? {{PAD_W{1'b0}}, cur_word} : '0;
    end

endmodule

// File: rtl/cipher_ctrl_reg_chk.sv
module cipher_ctrl_reg_chk #(
    parameter int ADDR_W = 4,
    parameter bit EN192  = 1'b1
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_hit,
    input logic       wd_mode_i,
    input logic       core_mode_o,
    input logic       core_mode_qe_o,
    input logic [2:0] core_keylen_o,
    input logic       core_keylen_qe_o,
    input logic       core_start_qe_o,
    input logic       core_fover_qe_o,
    input logic [2:0] keylen_q
);

    assert_core_keylen_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(core_keylen_o) == 1);

    assert_no_192_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !EN192 |-> core_keylen_o != 3'b010);

    assert_strobe_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hit |=> (core_mode_qe_o && core_keylen_qe_o && core_start_qe_o && core_fover_qe_o));

    assert_no_strobe_without_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_hit |=> !(core_mode_qe_o || core_keylen_qe_o || core_start_qe_o || core_fover_qe_o));

    assert_mode_takes_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hit |=> core_mode_o == $past(wd_mode_i));

    assert_writeback_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_keylen_qe_o |=> keylen_q == $past(core_keylen_o));

    assert_keylen_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_hit && !core_keylen_qe_o) |=> $stable(keylen_q));

endmodule

bind cipher_ctrl_reg cipher_ctrl_reg_chk #(.ADDR_W(ADDR_W), .EN192(EN192)) chk_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_hit           (wr_hit),
    .wd_mode_i        (sw_wdata_i[0]),
    .core_mode_o      (core_mode_o),
    .core_mode_qe_o   (core_mode_qe_o),
    .core_keylen_o    (core_keylen_o),
    .core_keylen_qe_o (core_keylen_qe_o),
    .core_start_qe_o  (core_start_qe_o),
    .core_fover_qe_o  (core_fover_qe_o),
    .keylen_q         (keylen_q)
);

// File: tb/cipher_ctrl_reg_tb_top.sv
module cipher_ctrl_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 32;
    localparam logic [ADDR_W-1:0] CTRL_A  = 4'h8;
    localparam logic [ADDR_W-1:0] OTHER_A = 4'h4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;

    logic [DATA_W-1:0] rd_a, rd_b;
    logic mode_a, mode_qe_a, kl_qe_a, st_a, st_qe_a, fo_a, fo_qe_a;
    logic mode_b, mode_qe_b, kl_qe_b, st_b, st_qe_b, fo_b, fo_qe_b;
    logic [2:0] kl_a, kl_b;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_A), .EN192(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sw_wr_en_i(wr_en), .sw_addr_i(addr), .sw_wdata_i(wdata),
        .sw_rdata_o(rd_a), .core_mode_o(mode_a), .core_mode_qe_o(mode_qe_a),
        .core_keylen_o(kl_a), .core_keylen_qe_o(kl_qe_a), .core_start_o(st_a),
        .core_start_qe_o(st_qe_a), .core_fover_o(fo_a), .core_fover_qe_o(fo_qe_a)
    );

    cipher_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_A), .EN192(1'b0)) dut_no192_i (
        .clk_i(clk), .rst_ni(rst_n), .sw_wr_en_i(wr_en), .sw_addr_i(addr), .sw_wdata_i(wdata),
        .sw_rdata_o(rd_b), .core_mode_o(mode_b), .core_mode_qe_o(mode_qe_b),
        .core_keylen_o(kl_b), .core_keylen_qe_o(kl_qe_b), .core_start_o(st_b),
        .core_start_qe_o(st_qe_b), .core_fover_o(fo_b), .core_fover_qe_o(fo_qe_b)
    );

    function automatic logic [2:0] exp_kl(input logic [2:0] code, input bit en192);
        if (code == 3'b001 || code == 3'b100) return code;
        if (code == 3'b010) return en192 ? 3'b010 : 3'b001;
        return 3'b001;
    endfunction

    function automatic logic [31:0] word(input bit fo, input bit st, input logic [2:0] kl, input bit md);
        return {26'd0, fo, st, kl, md};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        addr  = CTRL_A;
    endtask

    task automatic strobes(input logic [3:0] expv, input string tag);
        chk({mode_qe_a, kl_qe_a, st_qe_a, fo_qe_a} == expv, tag,
            {28'd0, mode_qe_a, kl_qe_a, st_qe_a, fo_qe_a}, {28'd0, expv});
        chk({mode_qe_b, kl_qe_b, st_qe_b, fo_qe_b} == expv, tag,
            {28'd0, mode_qe_b, kl_qe_b, st_qe_b, fo_qe_b}, {28'd0, expv});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1..all actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        addr  = CTRL_A;
        wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset value and idle strobes
        chk(rd_a == 32'h2, "R1 reset word en192", rd_a, 32'h2);
        chk(rd_b == 32'h2, "R1 reset word no192", rd_b, 32'h2);
        strobes(4'b0000, "R1 reset strobes");

        // R2: foreign address reads zero
        @(negedge clk);
        addr = OTHER_A;
        #1;
        chk(rd_a == 32'h0, "R2 foreign read", rd_a, 32'h0);
        chk(rd_b == 32'h0, "R2 foreign read", rd_b, 32'h0);
        addr = CTRL_A;

        // Sweep every key-length pattern on both builds
        for (int c = 0; c < 8; c++) begin
            logic [2:0] code;
            logic [2:0] ea, eb;
            bit md, st, fo;
            string tg;
            code = 3'(c);
            md = code[0]; st = code[1]; fo = code[2];
            ea = exp_kl(code, 1'b1);
            eb = exp_kl(code, 1'b0);
            if (code == 3'b001 || code == 3'b100) tg = "R5";
            else if (code == 3'b010) tg = "R6";
            else tg = "R7";
            do_write(CTRL_A, {{26{c[0]}}, fo, st, code, md});
            #1;
            // strobe cycle: raw stored, core sees legal code
            strobes(4'b1111, "R4 strobe after write");
            chk(kl_a == ea, "R9 core keylen en192", {29'd0, kl_a}, {29'd0, ea});
            chk(kl_b == eb, "R9 core keylen no192", {29'd0, kl_b}, {29'd0, eb});
            chk({fo_a, st_a, mode_a} == {fo, st, md}, "R3 flags en192",
                {29'd0, fo_a, st_a, mode_a}, {29'd0, fo, st, md});
            chk({fo_b, st_b, mode_b} == {fo, st, md}, "R3 flags no192",
                {29'd0, fo_b, st_b, mode_b}, {29'd0, fo, st, md});
            @(negedge clk);
            #1;
            strobes(4'b0000, "R4 strobe single cycle");
            chk(rd_a == word(fo, st, ea, md), {tg, " R8 readback en192"}, rd_a, word(fo, st, ea, md));
            chk(rd_b == word(fo, st, eb, md), {tg, " R8 readback no192"}, rd_b, word(fo, st, eb, md));
        end

        // R2: all-ones write masks upper bits, 111 -> 001
        do_write(CTRL_A, 32'hFFFF_FFFF);
        @(negedge clk);
        #1;
        chk(rd_a == 32'h33, "R2 upper bits zero", rd_a, 32'h33);
        chk(rd_b == 32'h33, "R2 upper bits zero", rd_b, 32'h33);

        // R11: write to other address has no effect
        do_write(OTHER_A, 32'h0000_0024);
        #1;
        strobes(4'b0000, "R11 no strobe");
        @(negedge clk);
        #1;
        chk(rd_a == 32'h33, "R11 word unchanged", rd_a, 32'h33);
        chk(rd_b == 32'h33, "R11 word unchanged", rd_b, 32'h33);

        // R10: back-to-back writes, write-back wins on key length
        @(negedge clk);
        wr_en = 1'b1; addr = CTRL_A; wdata = word(1'b0, 1'b0, 3'b010, 1'b0);
        @(posedge clk);
        @(negedge clk);
        wdata = word(1'b0, 1'b1, 3'b100, 1'b1);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        #1;
        chk(rd_a == word(1'b0, 1'b1, 3'b010, 1'b1), "R10 writeback priority en192",
            rd_a, word(1'b0, 1'b1, 3'b010, 1'b1));
        chk(rd_b == word(1'b0, 1'b1, 3'b001, 1'b1), "R10 writeback priority no192",
            rd_b, word(1'b0, 1'b1, 3'b001, 1'b1));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule